// File: doc/BRIEF.md
# End-of-Interrupt Write Handler

This block is the processor-side half of interrupt completion for the highest-priority interrupt group. An acknowledge input pushes the priority and identifier of each accepted interrupt onto a small active-priority stack and marks that identifier active. A 32-bit completion write names the identifier that software has finished with. When the identifier matches the most recent outstanding acknowledge, the block pulses a priority-drop output and pops the stack. The running priority then falls to the next stacked entry, or to all ones when nothing is left. Depending on a completion-mode bit, the same write may also deactivate the interrupt.

The completion-mode bit is picked from four control inputs according to the security configuration. Without the highest privilege level, the common bit applies. At that level and in its monitor mode, the dedicated top-level bit applies. Otherwise the secure or non-secure bit applies, following the current security state. Writes that name one of the reserved special identifiers are discarded without any effect. A write that matches nothing raises a one-cycle error and changes no state.

Top module: `eoi_wr_handler`

## Requirements
- R1: After reset the running priority is all ones (8'hFF by default), every active flag is 0, and prio_drop, deact and mismatch_err are 0.
- R2: An acknowledge with a non-special identifier is pushed onto the stack. From the following cycle the running priority equals the acknowledged priority, and the flag for that identifier is set.
- R3: An acknowledge whose identifier lies in 1020..1023 is ignored. The running priority and the active flags are unchanged.
- R4: A write whose identifier, bits [23:0], equals the identifier on top of the stack, with completion mode 0, pulses prio_drop and deact for exactly the next cycle with deact_id equal to that identifier. It pops the stack, so the running priority becomes the next entry or 8'hFF, and it clears the active flag.
- R5: The same matching write with completion mode 1 pulses prio_drop only and pops the stack. deact stays 0 and the active flag stays set.
- R6: The completion mode is chosen as follows. With el3_present=0 it is eoim_common. With el3_present=1 and monitor_mode=1 it is eoim_el3. Otherwise it is eoim_sec when secure=1 and eoim_nsec when secure=0.
- R7: A write whose identifier lies in 1020..1023 causes no drop, no deactivate and no error.
- R8: A non-special write that does not match the stack top, or that arrives while the stack is empty, pulses mismatch_err for one cycle. It leaves the running priority and the active flags unchanged.
- R9: Write-data bits [31:24] are ignored. With ID_BITS=16, bits [23:16] are ignored as well.
- R10: While the stack holds DEPTH entries (4 by default), an acknowledge that arrives without a simultaneous matching write is ignored. It sets no flag and does not change the priority.
- R11: When an acknowledge and a write fall in the same cycle, the write is judged against the stack as it was before that cycle. A matching write pops and the acknowledge pushes, so the running priority becomes the new acknowledged priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ack_valid | input | 1 | Acknowledge read returned an identifier |
| ack_id | input | 24 | Acknowledged identifier |
| ack_prio | input | PRIO_W | Priority of the acknowledged interrupt |
| wr_en | input | 1 | Completion write strobe |
| wr_data | input | 32 | Completion write data |
| el3_present | input | 1 | Highest privilege level implemented |
| monitor_mode | input | 1 | Core executes in monitor mode |
| secure | input | 1 | Current security state is secure |
| eoim_common | input | 1 | Completion mode, no top privilege level |
| eoim_el3 | input | 1 | Completion mode, monitor mode |
| eoim_sec | input | 1 | Completion mode, secure state |
| eoim_nsec | input | 1 | Completion mode, non-secure state |
| prio_drop | output | 1 | One-cycle priority-drop pulse |
| deact | output | 1 | One-cycle deactivate pulse |
| deact_id | output | 24 | Identifier named by the last accepted write |
| mismatch_err | output | 1 | One-cycle mismatched-write flag |
| run_prio | output | PRIO_W | Running priority, all ones when idle |
| act_flags | output | NUM_TRACK | Active flags for identifiers 0..NUM_TRACK-1 |

## Verification
Acknowledge and completion can land in the same cycle. This is provoked by driving ack_valid with a new identifier while wr_en names the current stack top, and it is repeated with a full stack. The expected outcome is a pop followed by a push. The drop and deactivate pulses must refer to the old top, the running priority must show the new one, and the flags must show the old identifier cleared and the new one set. A scoreboard predicts each outcome from the requirement rules and compares it one cycle after the stimulus.

// File: rtl/eoi_pkg.sv
package eoi_pkg;
   localparam int ID_W = 24;

   function automatic logic id_is_special(input logic [ID_W-1:0] id,
                                          input int lo, input int hi);
      return (id >= ID_W'(lo)) && (id <= ID_W'(hi));
   endfunction
endpackage

// File: rtl/eoi_mode_sel.sv
module eoi_mode_sel (
   input  logic el3_present,
   input  logic monitor_mode,
   input  logic secure,
   input  logic eoim_common,
   input  logic eoim_el3,
   input  logic eoim_sec,
   input  logic eoim_nsec,
   output logic drop_only
);
   always_comb begin
      if (!el3_present)      drop_only = eoim_common;
      else if (monitor_mode) drop_only = eoim_el3;
      else if (secure)       drop_only = eoim_sec;
      else                   drop_only = eoim_nsec;
   end
endmodule

// File: rtl/eoi_prio_stack.sv
module eoi_prio_stack #(
   parameter int DEPTH  = 4,
   parameter int PRIO_W = 8,
   parameter int IDW    = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              pop,
   input  logic [PRIO_W-1:0] push_prio,
   input  logic [IDW-1:0]    push_id,
   output logic              empty,
   output logic              full,
   output logic [PRIO_W-1:0] top_prio,
   output logic [IDW-1:0]    top_id
);
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 4) begin : g_bad_depth
      $error("eoi_prio_stack: DEPTH must be at least 4");
   end

   logic [CW-1:0]     cnt_q;
   logic [PRIO_W-1:0] prio_q [DEPTH];
   logic [IDW-1:0]    id_q   [DEPTH];

   assign empty = (cnt_q == '0);
   assign full  = (cnt_q == CW'(DEPTH));

   always_comb begin
      top_prio = '1;
      top_id   = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (CW'(i + 1) == cnt_q) begin
            top_prio = prio_q[i];
            top_id   = id_q[i];
         end
      end
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      logic wr_here;
      assign wr_here = push && ((pop  && CW'(g + 1) == cnt_q) ||
                                (!pop && !full && CW'(g) == cnt_q));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prio_q[g] <= '0;
            id_q[g]   <= '0;
         end else if (wr_here) begin
            prio_q[g] <= push_prio;
            id_q[g]   <= push_id;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        cnt_q <= '0;
      else if (push && !pop && !full)    cnt_q <= cnt_q + 1'b1;
      else if (pop && !push && !empty)   cnt_q <= cnt_q - 1'b1;
   end

   a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(DEPTH));
   a_r10_full_push_held: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> full);
   a_r8_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/eoi_active_tbl.sv
module eoi_active_tbl #(
   parameter int NUM_TRACK = 32,
   parameter int IDW       = 24
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 set_en,
   input  logic [IDW-1:0]       set_id,
   input  logic                 clr_en,
   input  logic [IDW-1:0]       clr_id,
   output logic [NUM_TRACK-1:0] flags
);
   for (genvar g = 0; g < NUM_TRACK; g++) begin : g_flag
      logic set_hit, clr_hit;
      assign set_hit = set_en && (set_id == IDW'(g));
      assign clr_hit = clr_en && (clr_id == IDW'(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       flags[g] <= 1'b0;
         else if (set_hit) flags[g] <= 1'b1;
         else if (clr_hit) flags[g] <= 1'b0;
      end
   end
endmodule

// File: rtl/eoi_wr_handler.sv
module eoi_wr_handler #(
   parameter int ID_BITS   = 24,
   parameter int PRIO_W    = 8,
   parameter int DEPTH     = 4,
   parameter int NUM_TRACK = 32,
   parameter int SPEC_LO   = 1020,
   parameter int SPEC_HI   = 1023
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      ack_valid,
   input  logic [eoi_pkg::ID_W-1:0]  ack_id,
   input  logic [PRIO_W-1:0]         ack_prio,
   input  logic                      wr_en,
   input  logic [31:0]               wr_data,
   input  logic                      el3_present,
   input  logic                      monitor_mode,
   input  logic                      secure,
   input  logic                      eoim_common,
   input  logic                      eoim_el3,
   input  logic                      eoim_sec,
   input  logic                      eoim_nsec,
   output logic                      prio_drop,
   output logic                      deact,
   output logic [eoi_pkg::ID_W-1:0]  deact_id,
   output logic                      mismatch_err,
   output logic [PRIO_W-1:0]         run_prio,
   output logic [NUM_TRACK-1:0]      act_flags
);
   import eoi_pkg::*;

   if (ID_BITS != 16 && ID_BITS != 24) begin : g_bad_idbits
      $error("eoi_wr_handler: ID_BITS must be 16 or 24");
   end
   if (SPEC_LO > SPEC_HI) begin : g_bad_spec
      $error("eoi_wr_handler: special range inverted");
   end

   logic [ID_W-1:0] wid, aid;
   logic            unused_bits;

   if (ID_BITS == 16) begin : g_id16
      assign wid = {8'h00, wr_data[15:0]};
      assign aid = {8'h00, ack_id[15:0]};
      assign unused_bits = ^{wr_data[31:16], ack_id[23:16]};
   end else begin : g_id24
      assign wid = wr_data[23:0];
      assign aid = ack_id;
      assign unused_bits = ^wr_data[31:24];
   end

   logic drop_only, st_empty, st_full;
   logic [PRIO_W-1:0] top_prio;
   logic [ID_W-1:0]   top_id;
   logic wr_spec, wr_hit, wr_miss, ack_ok, ack_take;

   eoi_mode_sel u_mode (
      .el3_present (el3_present),
      .monitor_mode(monitor_mode),
      .secure      (secure),
      .eoim_common (eoim_common),
      .eoim_el3    (eoim_el3),
      .eoim_sec    (eoim_sec),
      .eoim_nsec   (eoim_nsec),
      .drop_only   (drop_only)
   );

   assign wr_spec  = id_is_special(wid, SPEC_LO, SPEC_HI);
   assign wr_hit   = wr_en && !wr_spec && !st_empty && (top_id == wid);
   assign wr_miss  = wr_en && !wr_spec && !wr_hit;
   assign ack_ok   = ack_valid && !id_is_special(aid, SPEC_LO, SPEC_HI);
   assign ack_take = ack_ok && (!st_full || wr_hit);

   eoi_prio_stack #(.DEPTH(DEPTH), .PRIO_W(PRIO_W), .IDW(ID_W)) u_stack (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (ack_take),
      .pop      (wr_hit),
      .push_prio(ack_prio),
      .push_id  (aid),
      .empty    (st_empty),
      .full     (st_full),
      .top_prio (top_prio),
      .top_id   (top_id)
   );

   eoi_active_tbl #(.NUM_TRACK(NUM_TRACK), .IDW(ID_W)) u_act (
      .clk   (clk),
      .rst_n (rst_n),
      .set_en(ack_take),
      .set_id(aid),
      .clr_en(wr_hit && !drop_only),
      .clr_id(wid),
      .flags (act_flags)
   );

   assign run_prio = st_empty ? '1 : top_prio;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prio_drop    <= 1'b0;
         deact        <= 1'b0;
         deact_id     <= '0;
         mismatch_err <= 1'b0;
      end else begin
         prio_drop    <= wr_hit;
         deact        <= wr_hit && !drop_only;
         mismatch_err <= wr_miss;
         if (wr_hit) deact_id <= wid;
      end
   end

   a_r4_deact_needs_drop: assert property (@(posedge clk) disable iff (!rst_n)
      deact |-> prio_drop);
   a_r8_err_excludes_drop: assert property (@(posedge clk) disable iff (!rst_n)
      !(mismatch_err && prio_drop));
   a_r8_err_keeps_prio: assert property (@(posedge clk) disable iff (!rst_n)
      (mismatch_err && !$past(ack_take)) |-> $stable(run_prio));
   a_r7_special_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_spec) |=> !(prio_drop || mismatch_err));
endmodule

// File: tb/eoi_wr_handler_tb.sv
`timescale 1ns/1ps
module eoi_wr_handler_tb;
   localparam int PW = 8;
   localparam int NT = 32;

   logic clk = 1'b0, rst_n = 1'b0;
   logic ack_valid = 0, wr_en = 0;
   logic [23:0] ack_id = '0;
   logic [PW-1:0] ack_prio = '0;
   logic [31:0] wr_data = '0;
   logic el3_present = 0, monitor_mode = 0, secure = 0;
   logic eoim_common = 0, eoim_el3 = 0, eoim_sec = 0, eoim_nsec = 0;
   logic prio_drop, deact, mismatch_err;
   logic [23:0] deact_id;
   logic [PW-1:0] run_prio;
   logic [NT-1:0] act_flags;

   always #4 clk = ~clk;

   eoi_wr_handler u_dut (
      .clk(clk), .rst_n(rst_n), .ack_valid(ack_valid), .ack_id(ack_id),
      .ack_prio(ack_prio), .wr_en(wr_en), .wr_data(wr_data),
      .el3_present(el3_present), .monitor_mode(monitor_mode), .secure(secure),
      .eoim_common(eoim_common), .eoim_el3(eoim_el3), .eoim_sec(eoim_sec),
      .eoim_nsec(eoim_nsec), .prio_drop(prio_drop), .deact(deact),
      .deact_id(deact_id), .mismatch_err(mismatch_err), .run_prio(run_prio),
      .act_flags(act_flags)
   );

   typedef struct {
      logic          drop, dea, err;
      logic [23:0]   did;
      logic [PW-1:0] prio;
      logic [NT-1:0] act;
      string         tag;
   } exp_t;

   exp_t sbq[$];
   int n_chk = 0, n_fail = 0;

   // reference state, built from the requirement text
   logic [PW-1:0] mprio [4];
   logic [23:0]   mid   [4];
   int            mcnt = 0;
   logic [NT-1:0] mact = '0;

   function automatic bit spec(input logic [23:0] id);
      return id >= 24'd1020 && id <= 24'd1023;
   endfunction

   task automatic op(input bit av, input logic [23:0] aid, input logic [PW-1:0] ap,
                     input bit wv, input logic [31:0] wd, input string tag);
      exp_t e;
      logic [23:0] wid;
      bit hit, mode, take;
      @(negedge clk);
      ack_valid = av; ack_id = aid; ack_prio = ap; wr_en = wv; wr_data = wd;
      wid  = wd[23:0];
      hit  = wv && !spec(wid) && mcnt > 0 && mid[mcnt-1] == wid;
      mode = !el3_present ? eoim_common : monitor_mode ? eoim_el3 :
             secure ? eoim_sec : eoim_nsec;
      take = av && !spec(aid) && (mcnt < 4 || hit);
      e.drop = hit;
      e.dea  = hit && !mode;
      e.err  = wv && !spec(wid) && !hit;
      e.did  = hit ? wid : (sbq.size() > 0 ? sbq[$].did : last_did);
      if (hit) begin
         if (!mode && wid < NT) mact[wid] = 1'b0;
         mcnt--;
      end
      if (take) begin
         mprio[mcnt] = ap; mid[mcnt] = aid; mcnt++;
         if (aid < NT) mact[aid] = 1'b1;
      end
      if (hit) last_did = wid;
      e.prio = (mcnt == 0) ? '1 : mprio[mcnt-1];
      e.act  = mact;
      e.tag  = tag;
      sbq.push_back(e);
   endtask

   logic [23:0] last_did = '0;

   // monitor: compare shortly after the edge that registers each stimulus
   always @(posedge clk) begin
      #2;
      if (sbq.size() > 0) begin
         exp_t e;
         e = sbq.pop_front();
         n_chk++;
         if (prio_drop !== e.drop || deact !== e.dea || mismatch_err !== e.err ||
             run_prio !== e.prio || act_flags !== e.act ||
             (e.drop && deact_id !== e.did)) begin
            n_fail++;
            $display("FAIL %s: got drop=%b deact=%b id=%0d err=%b prio=%h act=%h exp drop=%b deact=%b id=%0d err=%b prio=%h act=%h",
                     e.tag, prio_drop, deact, deact_id, mismatch_err, run_prio, act_flags,
                     e.drop, e.dea, e.did, e.err, e.prio, e.act);
         end
      end
   end

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #(8 * 20000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hung run, expected completion");
      finish_run();
   end

   task automatic idle(); op(0, '0, '0, 0, '0, "idle"); endtask

   initial begin
      repeat (3) @(negedge clk);
      n_chk++;
      if (run_prio !== 8'hFF || act_flags !== '0 || prio_drop !== 0 ||
          deact !== 0 || mismatch_err !== 0) begin
         n_fail++;
         $display("FAIL R1: got prio=%h act=%h pulses=%b%b%b expected FF/0/000",
                  run_prio, act_flags, prio_drop, deact, mismatch_err);
      end
      rst_n = 1'b1;
      op(1, 24'd5, 8'h80, 0, '0, "R2 ack 5");
      op(1, 24'd1021, 8'h01, 0, '0, "R3 special ack");
      op(1, 24'd9, 8'h40, 0, '0, "R2 ack 9");
      op(0, '0, '0, 1, 32'hAB00_0005, "R8 mismatch");
      op(0, '0, '0, 1, 32'hFF00_0009, "R4 R9 complete 9");
      op(0, '0, '0, 1, 32'd1022, "R7 special write");
      @(negedge clk); el3_present = 1; monitor_mode = 1; eoim_el3 = 1;
      op(0, '0, '0, 1, 32'd5, "R5 R6 monitor drop-only");
      op(0, '0, '0, 1, 32'd5, "R8 empty-stack write");
      @(negedge clk); monitor_mode = 0; secure = 1; eoim_sec = 0; eoim_nsec = 1;
      op(1, 24'd7, 8'h30, 0, '0, "R2 ack 7");
      op(0, '0, '0, 1, 32'd7, "R6 secure mode 0");
      @(negedge clk); secure = 0;
      op(1, 24'd8, 8'h20, 0, '0, "R2 ack 8");
      op(0, '0, '0, 1, 32'd8, "R6 non-secure mode 1");
      op(1, 24'd10, 8'h10, 0, '0, "R2 fill");
      op(1, 24'd11, 8'h11, 0, '0, "R2 fill");
      op(1, 24'd12, 8'h12, 0, '0, "R2 fill");
      op(1, 24'd13, 8'h13, 0, '0, "R2 fill");
      op(1, 24'd14, 8'h14, 0, '0, "R10 full stack ack");
      @(negedge clk); eoim_nsec = 0;
      op(1, 24'd15, 8'h05, 1, 32'd13, "R11 ack and complete together");
      op(0, '0, '0, 1, 32'd15, "R4 pop to next");
      op(1, 24'd16, 8'h06, 1, 32'd16, "R11 write judged on old top");
      idle();
      while (sbq.size() > 0) @(negedge clk);
      finish_run();
   end
endmodule